// File: doc/BRIEF.md
# Two-Level Overcurrent Threshold Monitor

This block watches a stream of digitized phase-current samples and compares each one against two programmable levels. The lower level raises a warning flag that comes and goes with the current. The upper level sets a fault latch that holds a shutdown request towards the regulator controller until the fault is explicitly cleared. Both decisions need several consecutive qualifying samples, so an isolated noisy sample cannot trip anything. Samples taken just after a switching edge fall inside a blanking window and are not used at all.

The threshold pair is loaded through a small trim port: two codes and a one-cycle load strobe. A load is refused when the run-mode lock is high, when either code lies outside the allowed code window, or when the warning code is not strictly below the fault code. A refusal produces a one-cycle reject pulse and leaves the active pair unchanged. Until the first accepted load, a conservative pair fixed by parameters is in force. The active pair is visible on output ports.

Top module: `ilim_guard`

## Requirements
- R1: After synchronous reset, warn_flag, fault_latched, shutdown_req and cfg_reject are low, and warn_lvl/fault_lvl equal the parameters DEF_WARN/DEF_FAULT until a load is accepted.
- R2: A cfg_load with run_lock low, both codes within [CODE_MIN, CODE_MAX] and cfg_warn < cfg_fault makes warn_lvl/fault_lvl equal those codes in the next cycle, with no reject pulse.
- R3: A cfg_load where either code is below CODE_MIN or above CODE_MAX is refused: cfg_reject is high for exactly the next cycle and the active levels do not change.
- R4: A cfg_load with cfg_warn >= cfg_fault is refused in the same way as in R3.
- R5: A cfg_load while run_lock is high is refused in the same way as in R3, even when the codes would be valid.
- R6: When QUAL_N consecutive used samples are each >= fault_lvl, fault_latched rises in the cycle after the last of them. shutdown_req always equals fault_latched.
- R7: A used sample below a level restarts the consecutive count for that level, so QUAL_N-1 qualifying samples followed by one low sample change no flag.
- R8: warn_flag rises in the cycle after QUAL_N consecutive used samples >= warn_lvl and falls in the cycle after QUAL_N consecutive used samples < warn_lvl. It is not latched.
- R9: fault_latched stays high until fault_clr is high in the same cycle as a used sample below warn_lvl. A clear request alongside a sample at or above warn_lvl, and any threshold load, leave it high.
- R10: A sample that arrives in the cycle of an sw_edge pulse or in any of the BLANK_LEN cycles after it is not used: it affects no count, no flag and no clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Sample strobe |
| smp_val | input | CODE_W | Current sample code |
| sw_edge | input | 1 | Switching-edge pulse, starts blanking |
| cfg_warn | input | CODE_W | Requested warning level |
| cfg_fault | input | CODE_W | Requested fault level |
| cfg_load | input | 1 | Threshold load strobe |
| run_lock | input | 1 | Refuses threshold loads while high |
| fault_clr | input | 1 | Fault-latch clear request |
| warn_flag | output | 1 | Warning, unlatched |
| fault_latched | output | 1 | Latched fault |
| shutdown_req | output | 1 | Shutdown request to the controller |
| cfg_reject | output | 1 | One-cycle refusal pulse |
| warn_lvl | output | CODE_W | Active warning level |
| fault_lvl | output | CODE_W | Active fault level |

## Verification
The bench builds the monitor with a 10-bit sample, QUAL_N of 3, BLANK_LEN of 4, defaults of 200 and 300 and a code window of 16 to 1000. A qualification depth of 3 makes the "one short of the count" pattern and the reset-by-low-sample case reachable in a handful of samples, and a four-cycle blanking window lets the bench place samples at both sides of its last blanked cycle. The narrow code window puts both out-of-range directions within a few codes of legal values.

// File: rtl/ilim_pkg.sv
package ilim_pkg;

    // Reason a threshold load is refused; first match wins.
    typedef enum logic [1:0] {
        REJ_NONE  = 2'd0,
        REJ_LOCK  = 2'd1,
        REJ_RANGE = 2'd2,
        REJ_ORDER = 2'd3
    } rej_cause_e;

endpackage

// File: rtl/ilim_thresh_reg.sv
module ilim_thresh_reg
    import ilim_pkg::*;
#(
    parameter int unsigned CODE_W    = 10,
    parameter int unsigned DEF_WARN  = 200,
    parameter int unsigned DEF_FAULT = 300,
    parameter int unsigned CODE_MIN  = 16,
    parameter int unsigned CODE_MAX  = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_load,
    input  logic              run_lock,
    input  logic [CODE_W-1:0] cfg_warn,
    input  logic [CODE_W-1:0] cfg_fault,
    output logic [CODE_W-1:0] warn_lvl,
    output logic [CODE_W-1:0] fault_lvl,
    output logic              cfg_reject
);

    localparam logic [CODE_W-1:0] DW   = CODE_W'(DEF_WARN);
    localparam logic [CODE_W-1:0] DF   = CODE_W'(DEF_FAULT);
    localparam logic [CODE_W-1:0] CMIN = CODE_W'(CODE_MIN);
    localparam logic [CODE_W-1:0] CMAX = CODE_W'(CODE_MAX);

    typedef struct packed {
        logic [CODE_W-1:0] warn;
        logic [CODE_W-1:0] fault;
        logic              rej;
    } thr_st_t;

    thr_st_t    st_d, st_q;
    rej_cause_e cause;
    logic       out_of_win;

    always_comb begin
        st_d       = st_q;
        st_d.rej   = 1'b0;
        out_of_win = (cfg_warn < CMIN) || (cfg_warn > CMAX) ||
                     (cfg_fault < CMIN) || (cfg_fault > CMAX);
        if (run_lock)
            cause = REJ_LOCK;
        else if (out_of_win)
            cause = REJ_RANGE;
        else if (cfg_warn >= cfg_fault)
            cause = REJ_ORDER;
        else
            cause = REJ_NONE;
        if (cfg_load) begin
            if (cause != REJ_NONE) begin
                st_d.rej = 1'b1;
            end else begin
                st_d.warn  = cfg_warn;
                st_d.fault = cfg_fault;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '{warn: DW, fault: DF, rej: 1'b0};
        else
            st_q <= st_d;
    end

    assign warn_lvl   = st_q.warn;
    assign fault_lvl  = st_q.fault;
    assign cfg_reject = st_q.rej;

endmodule

// File: rtl/ilim_blank.sv
module ilim_blank #(
    parameter int unsigned BLANK_LEN = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic sw_edge,
    output logic blank
);

    localparam int unsigned     CW = $clog2(BLANK_LEN + 2);
    localparam logic [CW-1:0]   BL = CW'(BLANK_LEN);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } blk_st_t;

    blk_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sw_edge)
            st_d.cnt = BL;
        else if (st_q.cnt != '0)
            st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '{cnt: '0};
        else
            st_q <= st_d;
    end

    // The edge cycle itself is blanked, then BLANK_LEN further cycles.
    assign blank = sw_edge || (st_q.cnt != '0);

endmodule

// File: rtl/ilim_qual.sv
module ilim_qual #(
    parameter int unsigned CODE_W = 10,
    parameter int unsigned QUAL_N = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              use_smp,
    input  logic [CODE_W-1:0] smp_val,
    input  logic [CODE_W-1:0] warn_lvl,
    input  logic [CODE_W-1:0] fault_lvl,
    input  logic              clr_req,
    output logic              warn_flag,
    output logic              fault_lat
);

    localparam int unsigned   CW = $clog2(QUAL_N + 1);
    localparam logic [CW-1:0] NQ = CW'(QUAL_N);

    typedef struct packed {
        logic [CW-1:0] f_cnt;
        logic [CW-1:0] w_cnt;
        logic [CW-1:0] l_cnt;
        logic          warn;
        logic          fault;
    } q_st_t;

    q_st_t st_d, st_q;
    logic  hi_f, hi_w;

    function automatic logic [CW-1:0] bump(input logic [CW-1:0] c);
        return (c == NQ) ? c : c + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        hi_f = (smp_val >= fault_lvl);
        hi_w = (smp_val >= warn_lvl);
        if (use_smp) begin
            st_d.f_cnt = hi_f ? bump(st_q.f_cnt) : '0;
            st_d.w_cnt = hi_w ? bump(st_q.w_cnt) : '0;
            st_d.l_cnt = hi_w ? '0 : bump(st_q.l_cnt);
            if (st_d.w_cnt == NQ)
                st_d.warn = 1'b1;
            else if (st_d.l_cnt == NQ)
                st_d.warn = 1'b0;
            if (st_d.f_cnt == NQ)
                st_d.fault = 1'b1;
            else if (clr_req && !hi_w)
                st_d.fault = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '{f_cnt: '0, w_cnt: '0, l_cnt: '0, warn: 1'b0, fault: 1'b0};
        else
            st_q <= st_d;
    end

    assign warn_flag = st_q.warn;
    assign fault_lat = st_q.fault;

endmodule

// File: rtl/ilim_guard.sv
module ilim_guard #(
    parameter int unsigned CODE_W    = 10,
    parameter int unsigned QUAL_N    = 3,
    parameter int unsigned BLANK_LEN = 8,
    parameter int unsigned DEF_WARN  = 200,
    parameter int unsigned DEF_FAULT = 300,
    parameter int unsigned CODE_MIN  = 16,
    parameter int unsigned CODE_MAX  = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_vld,
    input  logic [CODE_W-1:0] smp_val,
    input  logic              sw_edge,
    input  logic [CODE_W-1:0] cfg_warn,
    input  logic [CODE_W-1:0] cfg_fault,
    input  logic              cfg_load,
    input  logic              run_lock,
    input  logic              fault_clr,
    output logic              warn_flag,
    output logic              fault_latched,
    output logic              shutdown_req,
    output logic              cfg_reject,
    output logic [CODE_W-1:0] warn_lvl,
    output logic [CODE_W-1:0] fault_lvl
);

    logic blank;
    logic use_smp;

    ilim_thresh_reg #(
        .CODE_W   (CODE_W),
        .DEF_WARN (DEF_WARN),
        .DEF_FAULT(DEF_FAULT),
        .CODE_MIN (CODE_MIN),
        .CODE_MAX (CODE_MAX)
    ) u_thr (
        .clk       (clk),
        .rst       (rst),
        .cfg_load  (cfg_load),
        .run_lock  (run_lock),
        .cfg_warn  (cfg_warn),
        .cfg_fault (cfg_fault),
        .warn_lvl  (warn_lvl),
        .fault_lvl (fault_lvl),
        .cfg_reject(cfg_reject)
    );

    ilim_blank #(
        .BLANK_LEN(BLANK_LEN)
    ) u_blank (
        .clk    (clk),
        .rst    (rst),
        .sw_edge(sw_edge),
        .blank  (blank)
    );

    assign use_smp = smp_vld && !blank;

    ilim_qual #(
        .CODE_W(CODE_W),
        .QUAL_N(QUAL_N)
    ) u_qual (
        .clk      (clk),
        .rst      (rst),
        .use_smp  (use_smp),
        .smp_val  (smp_val),
        .warn_lvl (warn_lvl),
        .fault_lvl(fault_lvl),
        .clr_req  (fault_clr),
        .warn_flag(warn_flag),
        .fault_lat(fault_latched)
    );

    assign shutdown_req = fault_latched;

endmodule

// File: rtl/ilim_guard_chk.sv
module ilim_guard_chk #(
    parameter int unsigned CODE_W   = 10,
    parameter int unsigned CODE_MIN = 16,
    parameter int unsigned CODE_MAX = 1000
) (
    input logic              clk,
    input logic              rst,
    input logic              smp_vld,
    input logic [CODE_W-1:0] smp_val,
    input logic              sw_edge,
    input logic [CODE_W-1:0] cfg_warn,
    input logic [CODE_W-1:0] cfg_fault,
    input logic              cfg_load,
    input logic              run_lock,
    input logic              fault_clr,
    input logic              warn_flag,
    input logic              fault_latched,
    input logic              shutdown_req,
    input logic              cfg_reject,
    input logic [CODE_W-1:0] warn_lvl,
    input logic [CODE_W-1:0] fault_lvl
);

    // R4
    order_kept_chk: assert property (@(posedge clk) disable iff (rst)
        warn_lvl < fault_lvl);

    // R2
    load_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_load && !run_lock && cfg_warn >= CODE_W'(CODE_MIN) && cfg_fault <= CODE_W'(CODE_MAX)
         && cfg_warn < cfg_fault)
        |=> (warn_lvl == $past(cfg_warn)) && (fault_lvl == $past(cfg_fault)) && !cfg_reject);

    // R5
    lock_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_load && run_lock) |=> cfg_reject && $stable(warn_lvl) && $stable(fault_lvl));

    // R3
    reject_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_reject && !$past(cfg_load)) |-> 1'b0);

    // R9
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fault_latched && !fault_clr) |=> fault_latched);

    // R6
    trip_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_latched) |-> $past(smp_vld && (smp_val >= fault_lvl)));

    // R6
    shutdown_tie_chk: assert property (@(posedge clk) disable iff (rst)
        shutdown_req == fault_latched);

    // R10
    blank_edge_chk: assert property (@(posedge clk) disable iff (rst)
        sw_edge |=> $stable(fault_latched) && $stable(warn_flag));

endmodule

bind ilim_guard ilim_guard_chk #(
    .CODE_W  (CODE_W),
    .CODE_MIN(CODE_MIN),
    .CODE_MAX(CODE_MAX)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .smp_vld      (smp_vld),
    .smp_val      (smp_val),
    .sw_edge      (sw_edge),
    .cfg_warn     (cfg_warn),
    .cfg_fault    (cfg_fault),
    .cfg_load     (cfg_load),
    .run_lock     (run_lock),
    .fault_clr    (fault_clr),
    .warn_flag    (warn_flag),
    .fault_latched(fault_latched),
    .shutdown_req (shutdown_req),
    .cfg_reject   (cfg_reject),
    .warn_lvl     (warn_lvl),
    .fault_lvl    (fault_lvl)
);

// File: tb/ilim_guard_bench.sv
module ilim_guard_bench;

    localparam int W = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         smp_vld = 1'b0;
    logic [W-1:0] smp_val = '0;
    logic         sw_edge = 1'b0;
    logic [W-1:0] cfg_warn = '0;
    logic [W-1:0] cfg_fault = '0;
    logic         cfg_load = 1'b0;
    logic         run_lock = 1'b0;
    logic         fault_clr = 1'b0;
    logic         warn_flag, fault_latched, shutdown_req, cfg_reject;
    logic [W-1:0] warn_lvl, fault_lvl;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    ilim_guard #(
        .CODE_W(W), .QUAL_N(3), .BLANK_LEN(4),
        .DEF_WARN(200), .DEF_FAULT(300), .CODE_MIN(16), .CODE_MAX(1000)
    ) u_ilim_guard (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_val(smp_val),
        .sw_edge(sw_edge), .cfg_warn(cfg_warn), .cfg_fault(cfg_fault),
        .cfg_load(cfg_load), .run_lock(run_lock), .fault_clr(fault_clr),
        .warn_flag(warn_flag), .fault_latched(fault_latched),
        .shutdown_req(shutdown_req), .cfg_reject(cfg_reject),
        .warn_lvl(warn_lvl), .fault_lvl(fault_lvl)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    // One sample, optionally with a clear request and/or a switching edge.
    task automatic smp(input int v, input bit clr = 1'b0, input bit edg = 1'b0);
        smp_vld = 1'b1; smp_val = W'(v); fault_clr = clr; sw_edge = edg;
        @(negedge clk);
        smp_vld = 1'b0; fault_clr = 1'b0; sw_edge = 1'b0;
    endtask

    task automatic load(input int w, input int f);
        cfg_load = 1'b1; cfg_warn = W'(w); cfg_fault = W'(f);
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic t_reset;
        chk_eq("R1 warn_flag", int'(warn_flag), 0);
        chk_eq("R1 fault_latched", int'(fault_latched), 0);
        chk_eq("R1 shutdown_req", int'(shutdown_req), 0);
        chk_eq("R1 cfg_reject", int'(cfg_reject), 0);
        chk_eq("R1 warn_lvl default", int'(warn_lvl), 200);
        chk_eq("R1 fault_lvl default", int'(fault_lvl), 300);
    endtask

    task automatic t_default_warn;
        smp(250); smp(250);
        chk_eq("R8 warn not yet after 2", int'(warn_flag), 0);
        smp(250);
        chk_eq("R8 warn after 3 at default level", int'(warn_flag), 1);
        chk_eq("R1 no fault under default fault level", int'(fault_latched), 0);
    endtask

    task automatic t_fault_qual;
        smp(350); smp(350); smp(100);
        chk_eq("R7 low sample restarts count", int'(fault_latched), 0);
        smp(350); smp(350);
        chk_eq("R7 two after restart", int'(fault_latched), 0);
        smp(350);
        chk_eq("R6 fault latched", int'(fault_latched), 1);
        chk_eq("R6 shutdown follows", int'(shutdown_req), 1);
    endtask

    task automatic t_clear;
        load(100, 500);
        chk_eq("R2 warn_lvl loaded", int'(warn_lvl), 100);
        chk_eq("R2 fault_lvl loaded", int'(fault_lvl), 500);
        chk_eq("R2 no reject", int'(cfg_reject), 0);
        chk_eq("R9 load does not clear latch", int'(fault_latched), 1);
        smp(400, 1'b1);
        chk_eq("R9 clear refused above warn", int'(fault_latched), 1);
        fault_clr = 1'b1; @(negedge clk); fault_clr = 1'b0;
        chk_eq("R9 clear refused without sample", int'(fault_latched), 1);
        smp(50, 1'b1);
        chk_eq("R9 clear accepted below warn", int'(fault_latched), 0);
        chk_eq("R6 shutdown drops with latch", int'(shutdown_req), 0);
    endtask

    task automatic t_range;
        load(5, 500);
        chk_eq("R3 low code reject pulse", int'(cfg_reject), 1);
        chk_eq("R3 warn_lvl kept", int'(warn_lvl), 100);
        @(negedge clk);
        chk_eq("R3 reject one cycle", int'(cfg_reject), 0);
        load(100, 1020);
        chk_eq("R3 high code reject pulse", int'(cfg_reject), 1);
        chk_eq("R3 fault_lvl kept", int'(fault_lvl), 500);
    endtask

    task automatic t_order;
        load(300, 300);
        chk_eq("R4 equal codes rejected", int'(cfg_reject), 1);
        load(400, 300);
        chk_eq("R4 inverted codes rejected", int'(cfg_reject), 1);
        chk_eq("R4 warn_lvl kept", int'(warn_lvl), 100);
        chk_eq("R4 fault_lvl kept", int'(fault_lvl), 500);
    endtask

    task automatic t_lock;
        run_lock = 1'b1;
        load(150, 600);
        chk_eq("R5 locked load rejected", int'(cfg_reject), 1);
        chk_eq("R5 warn_lvl kept", int'(warn_lvl), 100);
        run_lock = 1'b0;
        load(150, 600);
        chk_eq("R5 unlocked load no reject", int'(cfg_reject), 0);
        chk_eq("R2 new fault_lvl", int'(fault_lvl), 600);
    endtask

    task automatic t_warn_release;
        smp(200); smp(200); smp(200);
        chk_eq("R8 warn set at new level", int'(warn_flag), 1);
        smp(100); smp(100);
        chk_eq("R8 warn held after 2 low", int'(warn_flag), 1);
        smp(100);
        chk_eq("R8 warn released after 3 low", int'(warn_flag), 0);
    endtask

    task automatic t_blank;
        smp(700, 1'b0, 1'b1);
        for (int i = 0; i < 4; i++) smp(700);
        chk_eq("R10 blanked samples ignored", int'(fault_latched), 0);
        chk_eq("R10 blanked samples no warn", int'(warn_flag), 0);
        smp(700); smp(700);
        chk_eq("R10 two used after window", int'(fault_latched), 0);
        smp(700);
        chk_eq("R10 first unblanked sample counted", int'(fault_latched), 1);
        smp(50, 1'b1, 1'b1);
        chk_eq("R10 clear ignored while blanked", int'(fault_latched), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_default_warn;
        t_fault_qual;
        t_clear;
        t_range;
        t_order;
        t_lock;
        t_warn_release;
        t_blank;
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            chk(1'b0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule